// File: doc/BRIEF.md
# Two-Phase Timer Pair with Watchdog Reset

This peripheral holds two independent down-counting timers behind a small register bus made of a word address, write data, a write strobe and combinational read data. A running timer spends a programmed number of clock cycles in a high phase, then a programmed number of cycles in a low phase, and then repeats. Its output line follows the phase. In the last cycle of each period it raises a one-cycle interrupt pulse.

Timer 0 has a second use. When the low byte of its high-phase register holds 0xFF, the upper bits of that register set the high-phase length, and every completed period also drives a system reset line for a fixed number of cycles. If software clears the enable bit before the period ends, no reset is issued. The expected programming sequence is: clear the enable bit, write the counts, then set the enable bit again. Setting the enable bit always restarts the timer from its high phase, using the register values present at that moment.

Top module: `twin_phase_timer`

## Requirements
- R1: A synchronous reset with `rst_n` low clears every register to zero and drives `tmr_out`, `irq` and `wd_rst` low. This holds both at start-up and while the timers are running.
- R2: Byte offsets are 0x00 control, 0x04 timer 1 high count, 0x08 timer 0 high count, 0x0C timer 1 low count and 0x10 timer 0 low count. Each register reads back the last value written. Control bits [31:2] always read 0. Any other offset reads 0 and a write to it changes no register.
- R3: Control bit 0 enables timer 0 and bit 1 enables timer 1. When the write edge changes an enable bit from 0 to 1, the matching `tmr_out` bit goes high from the next clock edge and stays high for the high count in cycles.
- R4: After the high phase, `tmr_out` stays low for the low count in cycles. The pattern then repeats with period equal to high count plus low count.
- R5: `irq` for a timer is high for exactly one cycle per period, in the last cycle of the low phase.
- R6: A count of 0 in either phase acts as 1, so both counts at 0 give a 2-cycle period.
- R7: Clearing an enable bit drives that timer's `tmr_out` and `irq` low from the write edge on. It stops the timer and leaves the register contents unchanged.
- R8: Setting an enable bit again restarts the timer from the start of its high phase, using the counts held at that moment.
- R9: The two timers run independently when both are enabled together with different counts.
- R10: When bits [7:0] of the timer 0 high count equal 0xFF (watchdog mode), the timer 0 high phase lasts the value of bits [31:8] in cycles.
- R11: In watchdog mode, the clock edge that ends a timer 0 period starts a `wd_rst` pulse of 16 cycles. Outside watchdog mode, `wd_rst` stays low.
- R12: Clearing the timer 0 enable bit before its period ends prevents the watchdog reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 5 | Register byte offset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| tmr_out | output | 2 | Phase output per timer, high during the high phase |
| irq | output | 2 | One-cycle end-of-period interrupt per timer |
| wd_rst | output | 1 | Watchdog system reset pulse |

## Verification
The hardest case to reach is a watchdog period whose end is cut off by a disable write that lands only a few cycles before expiry. It must also be told apart from an expiry that has already fired its reset. The stimulus runs timer 0 in watchdog mode for one full period, checks the 16-cycle reset window cycle by cycle, and then clears the enable with a write that lands on the edge just before the second expiry. A later restart is then stopped part-way through the high phase, and the bench confirms that `wd_rst` never rises for 40 cycles afterwards.

// File: rtl/tpt_pkg.sv
// Shared definitions for the two-phase timer pair.
// Assumes a byte-addressed, word-aligned register window of 32 bytes.
package tpt_pkg;
    localparam int ADDR_W = 5;
    localparam int N_TMR  = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_HI_T1 = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_HI_T0 = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_LO_T1 = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_LO_T0 = 5'h10;

    localparam logic [7:0] WD_KEY = 8'hFF;

    typedef enum logic {PH_HIGH = 1'b0, PH_LOW = 1'b1} phase_e;
endpackage

// File: rtl/tpt_regs.sv
// Register file: control enables plus high/low count per timer.
// Assumes single-cycle writes; reads are combinational.
module tpt_regs
    import tpt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             addr,
    input  logic                          wr_en,
    input  logic [DATA_W-1:0]             wr_data,
    output logic [DATA_W-1:0]             rd_data,
    output logic [N_TMR-1:0]              en,
    output logic [N_TMR-1:0][DATA_W-1:0]  hi_cnt,
    output logic [N_TMR-1:0][DATA_W-1:0]  lo_cnt
);
    // Register update on bus writes; unmapped offsets are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en     <= '0;
            hi_cnt <= '0;
            lo_cnt <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_CTRL:  en        <= wr_data[N_TMR-1:0];
                OFS_HI_T1: hi_cnt[1] <= wr_data;
                OFS_HI_T0: hi_cnt[0] <= wr_data;
                OFS_LO_T1: lo_cnt[1] <= wr_data;
                OFS_LO_T0: lo_cnt[0] <= wr_data;
                default: ;
            endcase
        end
    end

    // Read multiplexer; control upper bits and holes read as zero.
    always_comb begin
        rd_data = '0;
        case (addr)
            OFS_CTRL:  rd_data[N_TMR-1:0] = en;
            OFS_HI_T1: rd_data = hi_cnt[1];
            OFS_HI_T0: rd_data = hi_cnt[0];
            OFS_LO_T1: rd_data = lo_cnt[1];
            OFS_LO_T0: rd_data = lo_cnt[0];
            default:   rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tpt_channel.sv
// One timer: high phase then low phase, repeating while enabled.
// Assumes counts of zero mean one cycle; restarts in the high phase
// on the first enabled cycle after being idle.
module tpt_channel
    import tpt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] hi_len,
    input  logic [CNT_W-1:0] lo_len,
    output logic             ph_out,
    output logic             end_pulse
);
    logic             run_q;
    phase_e           phase_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [CNT_W-1:0] reload(input logic [CNT_W-1:0] v);
        return (v == '0) ? '0 : v - 1'b1;
    endfunction

    // Phase sequencer: idle until enabled, then alternate the two counts.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            run_q   <= 1'b0;
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
        end else if (!run_q) begin
            run_q   <= 1'b1;
            phase_q <= PH_HIGH;
            cnt_q   <= reload(hi_len);
        end else if (cnt_q == '0) begin
            if (phase_q == PH_HIGH) begin
                phase_q <= PH_LOW;
                cnt_q   <= reload(lo_len);
            end else begin
                phase_q <= PH_HIGH;
                cnt_q   <= reload(hi_len);
            end
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Outputs gated by the enable so a disable silences them at once.
    always_comb begin
        ph_out    = en && run_q && (phase_q == PH_HIGH);
        end_pulse = en && run_q && (phase_q == PH_LOW) && (cnt_q == '0);
    end
endmodule

// File: rtl/tpt_wdog_rst.sv
// Stretches a one-cycle trigger into a fixed-length reset pulse.
// A trigger during an active pulse restarts the full length.
module tpt_wdog_rst #(
    parameter int RST_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic rst_out
);
    localparam int CW = $clog2(RST_CYCLES + 1);

    logic [CW-1:0] left_q;

    // Remaining-cycles counter for the reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (trig)           left_q <= CW'(RST_CYCLES);
        else if (left_q != '0)   left_q <= left_q - 1'b1;
    end

    // Pulse is active while cycles remain.
    assign rst_out = (left_q != '0);
endmodule

// File: rtl/twin_phase_timer.sv
// Top: register file, two two-phase timers, watchdog reset stretcher.
// Assumes timer 0 is the only one that can act as a watchdog.
module twin_phase_timer
    import tpt_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int RST_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        tmr_out,
    output logic [1:0]        irq,
    output logic              wd_rst
);
    logic [N_TMR-1:0]             ctrl_en;
    logic [N_TMR-1:0][DATA_W-1:0] hi_q;
    logic [N_TMR-1:0][DATA_W-1:0] lo_q;
    logic [N_TMR-1:0][DATA_W-1:0] hi_eff;
    logic                         wd_mode;

    tpt_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .en(ctrl_en), .hi_cnt(hi_q), .lo_cnt(lo_q)
    );

    // Watchdog key selects the upper field as timer 0 high length.
    always_comb begin
        wd_mode = (hi_q[0][7:0] == WD_KEY);
        hi_eff  = hi_q;
        if (wd_mode) hi_eff[0] = hi_q[0] >> 8;
    end

    for (genvar i = 0; i < N_TMR; i++) begin : g_tmr
        tpt_channel #(.CNT_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .en(ctrl_en[i]),
            .hi_len(hi_eff[i]), .lo_len(lo_q[i]),
            .ph_out(tmr_out[i]), .end_pulse(irq[i])
        );
    end

    tpt_wdog_rst #(.RST_CYCLES(RST_CYCLES)) u_wdr (
        .clk(clk), .rst_n(rst_n),
        .trig(irq[0] && wd_mode), .rst_out(wd_rst)
    );
endmodule

// File: rtl/tpt_checker.sv
// Temporal checks on the timer pair, bound into the top module.
module tpt_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [4:0]        addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        tmr_out,
    input logic [1:0]        irq,
    input logic              wd_rst,
    input logic [1:0]        en
);
    for (genvar i = 0; i < 2; i++) begin : g_chk
        // R5: interrupt never lasts two cycles
        a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |=> !irq[i]);
        // R5: interrupt only while the output is in its low phase
        a_r5_irq_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> !tmr_out[i]);
        // R7: a disabled timer is silent
        a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !en[i] |-> (!tmr_out[i] && !irq[i]));
    end

    // R11: reset pulse starts only after a timer 0 period end
    a_r11_rst_follows_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst) |-> $past(irq[0]));

    // R2: control upper bits read as zero
    a_r2_ctrl_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 5'h00) |-> (rd_data[DATA_W-1:2] == '0));
endmodule

bind twin_phase_timer tpt_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_data(rd_data),
    .tmr_out(tmr_out), .irq(irq), .wd_rst(wd_rst), .en(ctrl_en)
);

// File: tb/tb_twin_phase_timer.sv
`timescale 1ns/1ps
module tb_twin_phase_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [1:0]  tmr_out;
    logic [1:0]  irq;
    logic        wd_rst;
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    twin_phase_timer dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data),
        .tmr_out(tmr_out), .irq(irq), .wd_rst(wd_rst)
    );

    // {addr, write data, expected read}; R2 register map and holes
    localparam logic [68:0] VEC [6] = '{
        {5'h00, 32'hFFFF_FFFC, 32'h0000_0000},
        {5'h04, 32'h1111_1111, 32'h1111_1111},
        {5'h08, 32'h2222_2200, 32'h2222_2200},
        {5'h0C, 32'h3333_3333, 32'h3333_3333},
        {5'h10, 32'h4444_4444, 32'h4444_4444},
        {5'h14, 32'h0000_DEAD, 32'h0000_0000}
    };

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input logic [4:0] a, input logic [31:0] exp, input string tag);
        addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            fails++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, rd_data, exp);
        end
    endtask

    task automatic out_check(input string tag);
        checks++;
        if (tmr_out !== 2'b00 || irq !== 2'b00 || wd_rst !== 1'b0) begin
            fails++;
            $display("FAIL %s actual out=%b irq=%b wd=%b expected all 0", tag, tmr_out, irq, wd_rst);
        end
    endtask

    // Sample ncyc cycles after an enable write; one check per call.
    task automatic run_check(input int h0, input int l0, input int h1, input int l1,
                             input logic [1:0] m, input int ncyc,
                             input int wd_a, input int wd_b, input string tag);
        logic [1:0] eo, ei;
        logic ew;
        bit bad;
        bad = 0;
        for (int k = 1; k <= ncyc; k++) begin
            @(negedge clk);
            eo = '0; ei = '0;
            if (m[0]) begin
                eo[0] = ((k - 1) % (h0 + l0)) < h0;
                ei[0] = ((k - 1) % (h0 + l0)) == (h0 + l0 - 1);
            end
            if (m[1]) begin
                eo[1] = ((k - 1) % (h1 + l1)) < h1;
                ei[1] = ((k - 1) % (h1 + l1)) == (h1 + l1 - 1);
            end
            ew = (k >= wd_a) && (k <= wd_b);
            if (!bad && (tmr_out !== eo || irq !== ei || wd_rst !== ew)) begin
                bad = 1;
                $display("FAIL %s cycle=%0d actual out=%b irq=%b wd=%b expected out=%b irq=%b wd=%b",
                         tag, k, tmr_out, irq, wd_rst, eo, ei, ew);
            end
        end
        checks++;
        if (bad) fails++;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        out_check("R1 outputs after reset");
        rd_check(5'h00, 0, "R1 ctrl");
        rd_check(5'h04, 0, "R1 t1 high");
        rd_check(5'h08, 0, "R1 t0 high");
        rd_check(5'h0C, 0, "R1 t1 low");
        rd_check(5'h10, 0, "R1 t0 low");

        // R2: table walk
        for (int v = 0; v < 6; v++) begin
            wr(VEC[v][68:64], VEC[v][63:32]);
            rd_check(VEC[v][68:64], VEC[v][31:0], "R2 readback");
        end
        rd_check(5'h04, 32'h1111_1111, "R2 hole write ignored t1 high");
        rd_check(5'h10, 32'h4444_4444, "R2 hole write ignored t0 low");

        // R3 R4 R5: timer 1 high 4, low 3
        wr(5'h04, 4); wr(5'h0C, 3); wr(5'h00, 2);
        run_check(1, 1, 4, 3, 2'b10, 21, 1, 0, "R3 R4 R5 timer1 4/3");

        // R7: disable silences output and keeps registers
        wr(5'h00, 0);
        run_check(1, 1, 1, 1, 2'b00, 10, 1, 0, "R7 disabled quiet");
        rd_check(5'h04, 4, "R7 high count kept");
        rd_check(5'h0C, 3, "R7 low count kept");

        // R8: reprogram and re-enable
        wr(5'h04, 2); wr(5'h0C, 6); wr(5'h00, 2);
        run_check(1, 1, 2, 6, 2'b10, 24, 1, 0, "R8 reload 2/6");

        // R6: zero counts act as one
        wr(5'h00, 0); wr(5'h04, 0); wr(5'h0C, 0); wr(5'h00, 2);
        run_check(1, 1, 1, 1, 2'b10, 12, 1, 0, "R6 zero counts");

        // R9 R11: both timers, timer 0 in normal mode, no reset
        wr(5'h00, 0); wr(5'h08, 3); wr(5'h10, 4); wr(5'h04, 5); wr(5'h0C, 2);
        wr(5'h00, 3);
        run_check(3, 4, 5, 2, 2'b11, 35, 1, 0, "R9 R11 independent normal mode");

        // R10 R11: watchdog mode high 20, low 5, reset cycles 26..41
        wr(5'h00, 0); wr(5'h08, (20 << 8) | 32'hFF); wr(5'h10, 5); wr(5'h00, 1);
        run_check(20, 5, 1, 1, 2'b01, 48, 26, 41, "R10 R11 watchdog expiry");

        // R12: disable lands one edge before the second expiry
        wr(5'h00, 0);
        run_check(1, 1, 1, 1, 2'b00, 20, 1, 0, "R12 late disable no reset");
        wr(5'h00, 1);
        run_check(20, 5, 1, 1, 2'b01, 15, 1, 0, "R12 restart high phase");
        wr(5'h00, 0);
        run_check(1, 1, 1, 1, 2'b00, 40, 1, 0, "R12 early disable no reset");

        // R1: reset while running
        wr(5'h08, 2); wr(5'h10, 2); wr(5'h00, 3);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        out_check("R1 outputs after mid-run reset");
        rd_check(5'h00, 0, "R1 ctrl after mid-run reset");
        rd_check(5'h08, 0, "R1 t0 high after mid-run reset");
        rd_check(5'h0C, 0, "R1 t1 low after mid-run reset");
        repeat (4) @(negedge clk);
        out_check("R1 outputs stay idle");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule